// File: doc/BRIEF.md
# Serial Interface Clock Generator

This block supplies the bit clock for a host port that can run either SPI or I2C. In master mode it divides the system oscillator down through a chain of stages and drives the result out. That chain is a selectable 1-or-8 prescaler, an 8-bit modulus stage and a final toggle stage that halves the rate. In slave mode it passes an externally supplied serial clock through one register instead. For SPI it applies a programmable idle polarity. It also marks the edges on which data is to be sampled according to the phase setting, through a one-cycle qualifier.

The generator runs only while a transfer is active, and only in master mode or in I2C slave mode with clock-freeze set. Any change to the configuration restarts the divider from zero, so a partial half-period never reaches the output. In SPI master mode the block watches the slave-select input. If that input is driven low, it raises a sticky bus-error flag, which an explicit clear or a reset removes.

Top module: `serclk_gen`

## Requirements
- R1: With prescaler select 0 and modulus field 0x00 in master mode, the serial clock toggles on every oscillator cycle, giving half the oscillator frequency.
- R2: In master mode each half-period of the serial clock lasts P*(M+1) oscillator cycles, where P is 8 when the prescaler select bit is 1 and 1 when it is 0, and M is the modulus field.
- R3: The 8-bit modulus field covers ratios 1 to 256: field value M divides by M+1, so 0xFF gives 256.
- R4: In master mode with no transfer active, the serial clock sits at the polarity bit's level. Once a transfer starts, the first edge leaves that level after one full half-period, counted from the first active cycle.
- R5: The clock-enable qualifier is high for exactly the cycle in which an internally generated sampling edge appears. With phase 0 the sampling edges are those leaving the idle level; with phase 1 they are those returning to it.
- R6: In slave mode, when the I2C bit or the freeze bit is 0, the serial clock output equals the external clock delayed by one oscillator cycle, and the qualifier stays low even with a transfer active.
- R7: In slave mode with both the I2C bit and the freeze bit at 1, the internal generator keeps running: the qualifier pulses at the R2 rate and follows the R5 phase rule, while the output still follows the external clock.
- R8: A change to any configuration bit during a transfer returns the output to its idle level on the next cycle. Counting then restarts as if the transfer had just begun, and no edge from the old setting appears.
- R9: In master mode with the I2C bit 0, a low slave-select sets the bus-error flag on the next cycle, and the flag stays set after slave-select returns high.
- R10: The error clear input resets the flag unless the error condition is present in the same cycle, in which case setting wins. A low slave-select in I2C mode or in slave mode never sets the flag.
- R11: After reset the serial clock output, the qualifier and the bus-error flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 selects master mode (internal clock) |
| cfg_presc8 | input | 1 | 1 selects prescale by 8, 0 by 1 |
| cfg_div | input | DIV_W | Modulus field; divides by value plus one |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Sampling edge select |
| cfg_i2c | input | 1 | 1 selects I2C mode, 0 SPI |
| cfg_freeze | input | 1 | Keeps the generator running in I2C slave mode |
| xfer_active | input | 1 | A transfer is in progress |
| ext_sclk | input | 1 | Externally supplied serial clock |
| ss_n | input | 1 | Slave select, active low |
| err_clr | input | 1 | Clears the bus-error flag |
| sclk_out | output | 1 | Serial clock |
| sclk_en | output | 1 | One-cycle sampling-edge qualifier |
| bus_err | output | 1 | Sticky bus-error flag |

## Verification
The bench builds the block with its default parameters: an 8-bit modulus and a prescaler ratio of 8. The longest half-period is then 2048 cycles, so the extreme ratio and the 0xFF modulus are both exercised within a short run. A scoreboard predicts the exact cycle, level and qualifier value of every output edge. This makes an off-by-one in the modulus or prescaler, a wrong phase rule, or a runt edge after a configuration change show up as a mismatched or unscheduled event.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
  localparam int DIV_W = 8;

  typedef struct packed {
    logic             master;
    logic             presc8;
    logic [DIV_W-1:0] div;
    logic             cpol;
    logic             cpha;
    logic             i2c;
    logic             freeze;
  } serclk_cfg_t;
endpackage

// File: rtl/serclk_divider.sv
module serclk_divider #(
  parameter int DIV_W     = 8,
  parameter int PRE_RATIO = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             presc8,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic             pre_tick;
  logic [DIV_W-1:0] mod_cnt;

  generate
    if (PRE_RATIO > 1) begin : g_pre
      localparam int PRE_W = $clog2(PRE_RATIO);
      logic [PRE_W-1:0] pre_cnt;
      assign pre_tick = !presc8 || (pre_cnt == PRE_W'(PRE_RATIO - 1));
      always_ff @(posedge clk) begin
        if (rst || !run)   pre_cnt <= '0;
        else if (pre_tick) pre_cnt <= '0;
        else               pre_cnt <= pre_cnt + 1'b1;
      end
    end else begin : g_nopre
      assign pre_tick = 1'b1;
    end
  endgenerate

  assign tick = run && pre_tick && (mod_cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run)   mod_cnt <= '0;
    else if (pre_tick) mod_cnt <= (mod_cnt == div) ? '0 : mod_cnt + 1'b1;
  end

  // R3: the modulus counter never passes the programmed field while running
  a_r3_mod_in_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (mod_cnt <= div));
endmodule

// File: rtl/serclk_shaper.sv
module serclk_shaper (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  input  logic master,
  input  logic cpol,
  input  logic cpha,
  input  logic ext_sclk,
  output logic sclk_out,
  output logic sclk_en
);
  logic phase, phase_d;

  always_comb begin
    if (!run)      phase_d = 1'b0;
    else if (tick) phase_d = ~phase;
    else           phase_d = phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      sclk_out <= 1'b0;
      sclk_en  <= 1'b0;
    end else begin
      phase    <= phase_d;
      sclk_out <= master ? (cpol ^ phase_d) : ext_sclk;
      sclk_en  <= run && tick && (phase_d != cpha);
    end
  end

  // R2: the internal phase only moves on a divider tick
  a_r2_phase_holds: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(phase));
endmodule

// File: rtl/serclk_buserr.sv
module serclk_buserr (
  input  logic clk,
  input  logic rst,
  input  logic spi_master,
  input  logic ss_n,
  input  logic clr,
  output logic err
);
  always_ff @(posedge clk) begin
    if (rst)                     err <= 1'b0;
    else if (spi_master && !ss_n) err <= 1'b1;
    else if (clr)                err <= 1'b0;
  end

  // R9: the error appears one cycle after the condition
  a_r9_err_set: assert property (@(posedge clk) disable iff (rst)
    (spi_master && !ss_n) |=> err);
  // R9: the flag is sticky until cleared
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err && !clr) |=> err);
endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
  import serclk_pkg::*;
#(
  parameter int PRE_RATIO = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_master,
  input  logic             cfg_presc8,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_i2c,
  input  logic             cfg_freeze,
  input  logic             xfer_active,
  input  logic             ext_sclk,
  input  logic             ss_n,
  input  logic             err_clr,
  output logic             sclk_out,
  output logic             sclk_en,
  output logic             bus_err
);
  serclk_cfg_t cfg_now, cfg_q;
  logic        cfg_changed, gen_on, run, tick;

  assign cfg_now = '{master: cfg_master, presc8: cfg_presc8, div: cfg_div,
                     cpol: cfg_cpol, cpha: cfg_cpha, i2c: cfg_i2c,
                     freeze: cfg_freeze};

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_now;
  end

  assign cfg_changed = (cfg_now != cfg_q);
  assign gen_on      = cfg_master || (cfg_i2c && cfg_freeze);
  assign run         = gen_on && xfer_active && !cfg_changed;

  serclk_divider #(.DIV_W(DIV_W), .PRE_RATIO(PRE_RATIO)) u_div (
    .clk(clk), .rst(rst), .run(run), .presc8(cfg_presc8), .div(cfg_div),
    .tick(tick)
  );

  serclk_shaper u_shape (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .master(cfg_master),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .ext_sclk(ext_sclk),
    .sclk_out(sclk_out), .sclk_en(sclk_en)
  );

  serclk_buserr u_err (
    .clk(clk), .rst(rst), .spi_master(cfg_master && !cfg_i2c), .ss_n(ss_n),
    .clr(err_clr), .err(bus_err)
  );

  // R4: idle level in master mode without a transfer
  a_r4_idle_level: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && !xfer_active) |=> (sclk_out == $past(cfg_cpol)));
  // R6: slave output follows the external clock one cycle later
  a_r6_slave_follow: assert property (@(posedge clk) disable iff (rst)
    (!cfg_master) |=> (sclk_out == $past(ext_sclk)));
  // R7: the qualifier only fires when the generator was enabled
  a_r7_en_gated: assert property (@(posedge clk) disable iff (rst)
    sclk_en |-> $past(gen_on && xfer_active));
endmodule

// File: tb/serclk_gen_tb_top.sv
module serclk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_master = 0, cfg_presc8 = 0, cfg_cpol = 0, cfg_cpha = 0;
  logic       cfg_i2c = 0, cfg_freeze = 0, xfer_active = 0, ext_sclk = 0;
  logic       ss_n = 1, err_clr = 0;
  logic [7:0] cfg_div = 8'd0;
  logic       sclk_out, sclk_en, bus_err;

  int checks = 0, fails = 0, cyc = 0;
  logic cur_lvl = 1'b0, prev_out = 1'b0;

  typedef struct { int cyc; logic lvl; logic en; string tag; } exp_t;
  exp_t q[$];
  exp_t mon_e;

  serclk_gen dut_i (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_presc8(cfg_presc8),
    .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_i2c(cfg_i2c), .cfg_freeze(cfg_freeze), .xfer_active(xfer_active),
    .ext_sclk(ext_sclk), .ss_n(ss_n), .err_clr(err_clr),
    .sclk_out(sclk_out), .sclk_en(sclk_en), .bus_err(bus_err)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: every output edge or qualifier pulse must match the queue head
  always @(negedge clk) begin
    if (!rst) begin
      if (sclk_out !== prev_out || sclk_en) begin
        checks++;
        if (q.size() == 0) begin
          fails++;
          $display("FAIL R8 unscheduled event at cyc %0d: out=%b en=%b, expected none",
                   cyc, sclk_out, sclk_en);
        end else begin
          mon_e = q.pop_front();
          if (mon_e.cyc != cyc || mon_e.lvl !== sclk_out || mon_e.en !== sclk_en) begin
            fails++;
            $display("FAIL %s event: actual cyc=%0d out=%b en=%b, expected cyc=%0d out=%b en=%b",
                     mon_e.tag, cyc, sclk_out, sclk_en, mon_e.cyc, mon_e.lvl, mon_e.en);
          end
        end
      end
      prev_out = sclk_out;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic m, input logic p8, input logic [7:0] dv,
                         input logic pol, input logic pha, input logic i2, input logic fz);
    logic nl;
    nl = m ? pol : ext_sclk;
    if (nl !== cur_lvl) begin
      q.push_back('{cyc + 1, nl, 1'b0, "R4"});
      cur_lvl = nl;
    end
    cfg_master = m; cfg_presc8 = p8; cfg_div = dv; cfg_cpol = pol;
    cfg_cpha = pha; cfg_i2c = i2; cfg_freeze = fz;
    repeat (2) @(negedge clk);
  endtask

  // Driver: starts a transfer and schedules every expected edge
  task automatic run_burst(input int k, input string tag);
    int h, t;
    logic en;
    h = (cfg_presc8 ? 8 : 1) * (int'(cfg_div) + 1);
    t = cyc;
    xfer_active = 1'b1;
    for (int i = 1; i <= k; i++) begin
      en = ((i % 2) != 0) != cfg_cpha;
      if (cfg_master) begin
        cur_lvl = ~cur_lvl;
        q.push_back('{t + i * h, cur_lvl, en, tag});
      end else if (cfg_i2c && cfg_freeze && en) begin
        q.push_back('{t + i * h, cur_lvl, 1'b1, tag});
      end
    end
    while (cyc < t + k * h) @(negedge clk);
    xfer_active = 1'b0;
    if (cfg_master && cur_lvl !== cfg_cpol) begin
      q.push_back('{cyc + 1, cfg_cpol, 1'b0, tag});
      cur_lvl = cfg_cpol;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk_out, 1'b0, "R11 sclk_out after reset");
    chk(sclk_en,  1'b0, "R11 sclk_en after reset");
    chk(bus_err,  1'b0, "R11 bus_err after reset");

    // Fastest rate, phase 0
    set_cfg(1, 0, 8'd0, 0, 0, 0, 0);
    run_burst(6, "R1");
    // Modulus stage alone
    set_cfg(1, 0, 8'd2, 0, 0, 0, 0);
    run_burst(4, "R3");
    set_cfg(1, 0, 8'hFF, 0, 0, 0, 0);
    run_burst(2, "R3");
    // Prescaler by 8
    set_cfg(1, 1, 8'd0, 0, 0, 0, 0);
    run_burst(4, "R2");
    set_cfg(1, 1, 8'd3, 0, 1, 0, 0);
    run_burst(2, "R2");
    set_cfg(1, 1, 8'hFF, 0, 0, 0, 0);
    run_burst(2, "R2");
    // Inverted idle level and trailing-edge sampling
    set_cfg(1, 0, 8'd1, 1, 0, 0, 0);
    chk(sclk_out, 1'b1, "R4 idle level with polarity 1");
    run_burst(4, "R4");
    set_cfg(1, 0, 8'd1, 1, 1, 0, 0);
    run_burst(4, "R5");
    set_cfg(1, 0, 8'd0, 0, 1, 0, 0);
    run_burst(4, "R5");

    // Configuration change in the middle of a high half-period
    set_cfg(1, 0, 8'd3, 0, 0, 0, 0);
    t = cyc;
    xfer_active = 1'b1;
    q.push_back('{t + 4, 1'b1, 1'b1, "R8"});
    while (cyc < t + 4) @(negedge clk);
    cfg_div = 8'd1;
    q.push_back('{cyc + 1, 1'b0, 1'b0, "R8"});
    t = cyc + 1;
    q.push_back('{t + 2, 1'b1, 1'b1, "R8"});
    q.push_back('{t + 4, 1'b0, 1'b0, "R8"});
    cur_lvl = 1'b0;
    while (cyc < t + 4) @(negedge clk);
    xfer_active = 1'b0;
    repeat (3) @(negedge clk);

    // Bus error in SPI master mode
    ss_n = 1'b0;
    @(negedge clk);
    chk(bus_err, 1'b1, "R9 set on low slave select");
    ss_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_err, 1'b1, "R9 sticky after release");
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(bus_err, 1'b0, "R10 cleared by err_clr");
    ss_n = 1'b0; err_clr = 1'b1;
    @(negedge clk);
    ss_n = 1'b1; err_clr = 1'b0;
    chk(bus_err, 1'b1, "R10 set wins over clear");
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(bus_err, 1'b0, "R10 clear again");

    // I2C master: slave select ignored
    set_cfg(1, 0, 8'd0, 0, 0, 1, 0);
    ss_n = 1'b0;
    repeat (2) @(negedge clk);
    ss_n = 1'b1;
    chk(bus_err, 1'b0, "R10 no error in I2C master");

    // Slave mode, generator off
    set_cfg(0, 0, 8'd0, 0, 0, 0, 0);
    ss_n = 1'b0;
    repeat (2) @(negedge clk);
    ss_n = 1'b1;
    chk(bus_err, 1'b0, "R10 no error in slave mode");
    xfer_active = 1'b1;
    for (int i = 0; i < 4; i++) begin
      ext_sclk = ~ext_sclk;
      q.push_back('{cyc + 1, ext_sclk, 1'b0, "R6"});
      cur_lvl = ext_sclk;
      repeat (3) @(negedge clk);
    end
    xfer_active = 1'b0;
    repeat (2) @(negedge clk);

    // I2C slave with clock freeze: generator keeps running
    set_cfg(0, 0, 8'd1, 0, 0, 1, 1);
    run_burst(4, "R7");
    set_cfg(0, 0, 8'd0, 0, 1, 1, 1);
    run_burst(4, "R7");

    repeat (4) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing events: actual %0d pending expected 0", q.size());
    end
    summary();
    $finish;
  end
endmodule